// File: doc/BRIEF.md
# SPI Transfer Request Parameter Validator

This block screens one SPI transfer request against the capability set of the host SPI controller before the transfer engine starts. The capability set and the request fields are held on the block's inputs. The request fields are chip-select index, word length, write and read lane widths, mode word, clock frequency and four delay values. A one-cycle start strobe asks for a check. One cycle later the block pulses a valid flag together with a two-bit status. It also raises a launch-enable flag when the request is clean.

The checks use several encodings:
- Some capability fields use zero to mean "no limit". Others use zero to mean "not supported".
- The clock phase and clock polarity capabilities are two-bit selectors.
- The lane-width capabilities are per-width permission bits.

Once a transfer has been launched, the engine can report a failure on a separate strobe. The block then reports the transfer-error code through the same valid/status outputs.

Top module: `spi_req_validator`

## Requirements
- R1: When `start_i` is high at a rising edge and `xfer_fail_i` is low, then after that edge `valid_o` is high for exactly one cycle and `status_o` carries the verdict: 0 for success, 1 for a parameter error. `valid_o` is low in every cycle that does not follow a start or failure strobe.
- R2: `launch_o` is high only together with `valid_o` and `status_o` equal to 0. It is high for every successful check.
- R3: A chip-select index greater than or equal to `cap_cs_count_i` gives status 1, so a count of 0 rejects every request.
- R4: If the word-length mask is zero, any word length is accepted. Otherwise a word length `n` passes only when 1 ≤ n ≤ MASK_W and mask bit `n-1` is set, and all other values give status 1.
- R5: Each lane-width request is checked against its own 3-bit capability. Values 0 and 1 (single lane) always pass. Value 2 needs capability bit 0, value 4 needs bit 1, and value 8 needs bit 2. Any other value gives status 1.
- R6: Clock phase is request mode bit 0 and is checked against capability bits 1:0. Clock polarity is mode bit 1 and is checked against capability bits 3:2. In each two-bit selector, 00 allows both values, 01 allows only 0, 10 allows only 1, and 11 rejects every request.
- R7: Request mode bit 2 (active-high chip-select), bit 3 (LSB first) and bit 4 (loopback) are rejected when capability bit 4, 5 or 6 respectively is clear. Any request mode bit above bit 4 gives status 1.
- R8: A maximum frequency of 0 means no limit. Otherwise a request frequency above the maximum gives status 1, and a request frequency equal to the maximum passes.
- R9: For each of the word delay, setup, hold and inactive delays, a capability of 0 rejects any non-zero request. A non-zero capability rejects requests above it and accepts requests equal to it.
- R10: When `xfer_fail_i` is high at a rising edge, `valid_o` pulses next cycle with `status_o` = 2 and `launch_o` low. This holds even if `start_i` is high in the same cycle.
- R11: While reset is asserted and until the first strobe, `valid_o`, `launch_o` and `status_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Check strobe |
| xfer_fail_i | input | 1 | Transfer failure strobe from the engine |
| cap_cs_count_i | input | CS_W | Number of chip-selects available |
| cap_tx_lanes_i | input | 3 | Write lane permissions: dual, quad, octal |
| cap_rx_lanes_i | input | 3 | Read lane permissions: dual, quad, octal |
| cap_bpw_mask_i | input | MASK_W | Allowed word lengths; 0 allows all |
| cap_mode_i | input | 7 | Phase/polarity selectors and mode permissions |
| cap_max_freq_i | input | FREQ_W | Maximum clock frequency; 0 is no limit |
| cap_max_word_dly_i | input | DLY_W | Maximum word delay; 0 is unsupported |
| cap_max_setup_i | input | DLY_W | Maximum setup delay; 0 is unsupported |
| cap_max_hold_i | input | DLY_W | Maximum hold delay; 0 is unsupported |
| cap_max_inact_i | input | DLY_W | Maximum inactive delay; 0 is unsupported |
| req_cs_i | input | CS_W | Requested chip-select index |
| req_bpw_i | input | BPW_W | Requested word length |
| req_tx_lanes_i | input | LANE_W | Requested write lane width |
| req_rx_lanes_i | input | LANE_W | Requested read lane width |
| req_mode_i | input | MODE_W | Requested mode word |
| req_freq_i | input | FREQ_W | Requested frequency |
| req_word_dly_i | input | DLY_W | Requested word delay |
| req_setup_i | input | DLY_W | Requested setup delay |
| req_hold_i | input | DLY_W | Requested hold delay |
| req_inact_i | input | DLY_W | Requested inactive delay |
| valid_o | output | 1 | Status valid pulse |
| status_o | output | 2 | 0 success, 1 parameter error, 2 transfer error |
| launch_o | output | 1 | Transfer may start |

## Verification
The bench builds the block with its default parameters: 8-bit chip-select and word-length fields, a 32-bit word-length mask, 8-bit lane fields and 32-bit mode, frequency and delay fields.

With a 32-bit mask, word lengths 0, 32 and 33 sit exactly on the edges of the mask rule. With a 32-bit mode word, a request can set a mode bit well above bit 4. The random fields are drawn from narrow ranges, so that a capability of zero, equality with a limit and one above a limit all occur often.

// File: rtl/spi_chk_pkg.sv
package spi_chk_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_PARAM = 2'd1,
    ST_XFER  = 2'd2
  } status_e;

  // request mode word bit positions
  localparam int MB_PHASE = 0;
  localparam int MB_POL   = 1;
  localparam int MB_CSHI  = 2;
  localparam int MB_LSB   = 3;
  localparam int MB_LOOP  = 4;
  localparam int MB_LAST  = MB_LOOP;

  // capability mode bit positions
  localparam int CB_PHASE = 0;
  localparam int CB_POL   = 2;
  localparam int CB_CSHI  = 4;
  localparam int CB_LSB   = 5;
  localparam int CB_LOOP  = 6;
  localparam int CAP_MODE_W = CB_LOOP + 1;
endpackage

// File: rtl/spi_limit_chk.sv
module spi_limit_chk #(
  parameter int   W              = 32,
  parameter logic ZERO_UNLIMITED = 1'b1
) (
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] max_i,
  output logic         bad_o
);
  logic over;
  assign over = req_i > max_i;

  generate
    if (ZERO_UNLIMITED) begin : g_unlim
      assign bad_o = (max_i != '0) && over;
    end else begin : g_unsup
      assign bad_o = (max_i == '0) ? (req_i != '0) : over;
    end
  endgenerate
endmodule

// File: rtl/spi_lane_chk.sv
module spi_lane_chk #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] req_i,
  input  logic [2:0]    cap_i,
  output logic          bad_o
);
  always_comb begin
    case (req_i)
      LW'(0), LW'(1): bad_o = 1'b0;
      LW'(2):         bad_o = !cap_i[0];
      LW'(4):         bad_o = !cap_i[1];
      LW'(8):         bad_o = !cap_i[2];
      default:        bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_mode_chk.sv
module spi_mode_chk
  import spi_chk_pkg::*;
#(
  parameter int MW = 32
) (
  input  logic [MW-1:0]         req_i,
  input  logic [CAP_MODE_W-1:0] cap_i,
  output logic                  bad_o
);
  function automatic logic sel_bad(input logic [1:0] allow, input logic v);
    case (allow)
      2'b00:   sel_bad = 1'b0;
      2'b01:   sel_bad = v;
      2'b10:   sel_bad = !v;
      default: sel_bad = 1'b1;
    endcase
  endfunction

  logic hi_bad, feat_bad, clk_bad;

  generate
    if (MW > MB_LAST + 1) begin : g_hi
      assign hi_bad = |req_i[MW-1:MB_LAST+1];
    end else begin : g_nohi
      assign hi_bad = 1'b0;
    end
  endgenerate

  assign clk_bad = sel_bad(cap_i[CB_PHASE+:2], req_i[MB_PHASE])
                 | sel_bad(cap_i[CB_POL+:2],   req_i[MB_POL]);

  assign feat_bad = (req_i[MB_CSHI] & !cap_i[CB_CSHI])
                  | (req_i[MB_LSB]  & !cap_i[CB_LSB])
                  | (req_i[MB_LOOP] & !cap_i[CB_LOOP]);

  assign bad_o = hi_bad | clk_bad | feat_bad;
endmodule

// File: rtl/spi_req_validator.sv
module spi_req_validator
  import spi_chk_pkg::*;
#(
  parameter int CS_W   = 8,
  parameter int BPW_W  = 8,
  parameter int MASK_W = 32,
  parameter int LANE_W = 8,
  parameter int MODE_W = 32,
  parameter int FREQ_W = 32,
  parameter int DLY_W  = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  xfer_fail_i,
  input  logic [CS_W-1:0]       cap_cs_count_i,
  input  logic [2:0]            cap_tx_lanes_i,
  input  logic [2:0]            cap_rx_lanes_i,
  input  logic [MASK_W-1:0]     cap_bpw_mask_i,
  input  logic [CAP_MODE_W-1:0] cap_mode_i,
  input  logic [FREQ_W-1:0]     cap_max_freq_i,
  input  logic [DLY_W-1:0]      cap_max_word_dly_i,
  input  logic [DLY_W-1:0]      cap_max_setup_i,
  input  logic [DLY_W-1:0]      cap_max_hold_i,
  input  logic [DLY_W-1:0]      cap_max_inact_i,
  input  logic [CS_W-1:0]       req_cs_i,
  input  logic [BPW_W-1:0]      req_bpw_i,
  input  logic [LANE_W-1:0]     req_tx_lanes_i,
  input  logic [LANE_W-1:0]     req_rx_lanes_i,
  input  logic [MODE_W-1:0]     req_mode_i,
  input  logic [FREQ_W-1:0]     req_freq_i,
  input  logic [DLY_W-1:0]      req_word_dly_i,
  input  logic [DLY_W-1:0]      req_setup_i,
  input  logic [DLY_W-1:0]      req_hold_i,
  input  logic [DLY_W-1:0]      req_inact_i,
  output logic                  valid_o,
  output logic [1:0]            status_o,
  output logic                  launch_o
);
  localparam int NDLY = 4;

  logic                       cs_bad, bpw_bad, tx_bad, rx_bad, mode_bad, freq_bad;
  logic [NDLY-1:0]            dly_bad;
  logic [NDLY-1:0][DLY_W-1:0] dly_req, dly_cap;
  logic                       param_bad;
  logic                       valid_q, launch_q;
  status_e                    status_q;

  assign cs_bad = req_cs_i >= cap_cs_count_i;

  // mask bit n-1 covers word length n
  always_comb begin
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < MASK_W; i++) begin
      if ((int'(req_bpw_i) == i + 1) && cap_bpw_mask_i[i]) hit = 1'b1;
    end
    bpw_bad = (cap_bpw_mask_i != '0) && !hit;
  end

  spi_lane_chk #(.LW(LANE_W)) u_tx_lane (
    .req_i(req_tx_lanes_i), .cap_i(cap_tx_lanes_i), .bad_o(tx_bad)
  );
  spi_lane_chk #(.LW(LANE_W)) u_rx_lane (
    .req_i(req_rx_lanes_i), .cap_i(cap_rx_lanes_i), .bad_o(rx_bad)
  );

  spi_mode_chk #(.MW(MODE_W)) u_mode (
    .req_i(req_mode_i), .cap_i(cap_mode_i), .bad_o(mode_bad)
  );

  spi_limit_chk #(.W(FREQ_W), .ZERO_UNLIMITED(1'b1)) u_freq (
    .req_i(req_freq_i), .max_i(cap_max_freq_i), .bad_o(freq_bad)
  );

  assign dly_req = {req_inact_i, req_hold_i, req_setup_i, req_word_dly_i};
  assign dly_cap = {cap_max_inact_i, cap_max_hold_i, cap_max_setup_i, cap_max_word_dly_i};

  generate
    for (genvar g = 0; g < NDLY; g++) begin : g_dly
      spi_limit_chk #(.W(DLY_W), .ZERO_UNLIMITED(1'b0)) u_dly (
        .req_i(dly_req[g]), .max_i(dly_cap[g]), .bad_o(dly_bad[g])
      );
    end
  endgenerate

  assign param_bad = cs_bad | bpw_bad | tx_bad | rx_bad | mode_bad | freq_bad | (|dly_bad);

  // failure report wins over a same-cycle start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      launch_q <= 1'b0;
      status_q <= ST_OK;
    end else begin
      valid_q  <= start_i | xfer_fail_i;
      launch_q <= start_i & !xfer_fail_i & !param_bad;
      if (xfer_fail_i)  status_q <= ST_XFER;
      else if (start_i) status_q <= param_bad ? ST_PARAM : ST_OK;
    end
  end

  assign valid_o  = valid_q;
  assign launch_o = launch_q;
  assign status_o = status_q;

  // R2
  launch_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> (valid_o && status_o == 2'd0));

  // R1
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(start_i) || $past(xfer_fail_i)));

  // R1
  start_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  // R10
  xfer_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_fail_i |=> (valid_o && status_o == 2'd2 && !launch_o));

  // R6
  phase_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !xfer_fail_i && cap_mode_i[CB_PHASE+:2] == 2'b11) |=> (status_o == 2'd1));

  // R3
  cs_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !xfer_fail_i && req_cs_i >= cap_cs_count_i) |=> !launch_o);
endmodule

// File: tb/spi_req_validator_tb.sv
module spi_req_validator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, fail = 1'b0;
  logic [7:0]  cap_cs = '0;
  logic [2:0]  cap_tx = '0, cap_rx = '0;
  logic [31:0] cap_mask = '0;
  logic [6:0]  cap_mode = '0;
  logic [31:0] cap_freq = '0, cap_wd = '0, cap_su = '0, cap_ho = '0, cap_in = '0;
  logic [7:0]  r_cs = '0, r_bpw = '0, r_tx = '0, r_rx = '0;
  logic [31:0] r_mode = '0, r_freq = '0, r_wd = '0, r_su = '0, r_ho = '0, r_in = '0;
  logic        valid, launch;
  logic [1:0]  status;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  spi_req_validator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .xfer_fail_i(fail),
    .cap_cs_count_i(cap_cs), .cap_tx_lanes_i(cap_tx), .cap_rx_lanes_i(cap_rx),
    .cap_bpw_mask_i(cap_mask), .cap_mode_i(cap_mode), .cap_max_freq_i(cap_freq),
    .cap_max_word_dly_i(cap_wd), .cap_max_setup_i(cap_su), .cap_max_hold_i(cap_ho),
    .cap_max_inact_i(cap_in), .req_cs_i(r_cs), .req_bpw_i(r_bpw),
    .req_tx_lanes_i(r_tx), .req_rx_lanes_i(r_rx), .req_mode_i(r_mode),
    .req_freq_i(r_freq), .req_word_dly_i(r_wd), .req_setup_i(r_su),
    .req_hold_i(r_ho), .req_inact_i(r_in),
    .valid_o(valid), .status_o(status), .launch_o(launch)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit lane_bad(input logic [7:0] v, input logic [2:0] c);
    if (v == 0 || v == 1) return 0;
    if (v == 2) return !c[0];
    if (v == 4) return !c[1];
    if (v == 8) return !c[2];
    return 1;
  endfunction

  function automatic bit sel_bad(input logic [1:0] a, input logic v);
    if (a == 2'b00) return 0;
    if (a == 2'b01) return v;
    if (a == 2'b10) return !v;
    return 1;
  endfunction

  function automatic bit dly_bad(input logic [31:0] rq, input logic [31:0] mx);
    if (mx == 0) return rq != 0;
    return rq > mx;
  endfunction

  function automatic int exp_status();
    bit bad = 0;
    if (r_cs >= cap_cs) bad = 1;                                  // R3
    if (cap_mask != 0) begin                                      // R4
      if (r_bpw == 0 || r_bpw > 32) bad = 1;
      else if (!cap_mask[r_bpw-1]) bad = 1;
    end
    if (lane_bad(r_tx, cap_tx) || lane_bad(r_rx, cap_rx)) bad = 1; // R5
    if (sel_bad(cap_mode[1:0], r_mode[0])) bad = 1;                // R6
    if (sel_bad(cap_mode[3:2], r_mode[1])) bad = 1;
    if (r_mode[2] && !cap_mode[4]) bad = 1;                        // R7
    if (r_mode[3] && !cap_mode[5]) bad = 1;
    if (r_mode[4] && !cap_mode[6]) bad = 1;
    if (r_mode[31:5] != 0) bad = 1;
    if (cap_freq != 0 && r_freq > cap_freq) bad = 1;               // R8
    if (dly_bad(r_wd, cap_wd) || dly_bad(r_su, cap_su) ||          // R9
        dly_bad(r_ho, cap_ho) || dly_bad(r_in, cap_in)) bad = 1;
    return bad ? 1 : 0;
  endfunction

  // permissive capabilities and a clean request
  task automatic set_clean();
    cap_cs = 8'd4; cap_tx = 3'b111; cap_rx = 3'b111; cap_mask = '0; cap_mode = 7'b111_0000;
    cap_freq = 32'd100; cap_wd = 32'd10; cap_su = 32'd10; cap_ho = 32'd10; cap_in = 32'd10;
    r_cs = 8'd0; r_bpw = 8'd8; r_tx = 8'd1; r_rx = 8'd1; r_mode = '0;
    r_freq = 32'd50; r_wd = '0; r_su = '0; r_ho = '0; r_in = '0;
  endtask

  // pulse start at a falling edge, check after the next rising edge
  task automatic run(input string tag);
    int e;
    e = exp_status();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk({tag, " R1 valid"}, int'(valid), 1);
    chk({tag, " status"}, int'(status), e);
    chk({tag, " R2 launch"}, int'(launch), (e == 0) ? 1 : 0);
    @(negedge clk);
    chk({tag, " R1 single pulse"}, int'(valid), 0);
    chk({tag, " R2 launch idle"}, int'(launch), 0);
  endtask

  task automatic randomize_fields();
    logic [7:0] lanes [8] = '{8'd0, 8'd1, 8'd2, 8'd4, 8'd8, 8'd3, 8'd5, 8'd16};
    cap_cs   = 8'($urandom_range(0, 4));
    r_cs     = 8'($urandom_range(0, 5));
    cap_tx   = 3'($urandom);
    cap_rx   = 3'($urandom);
    r_tx     = lanes[$urandom_range(0, 7)];
    r_rx     = lanes[$urandom_range(0, 7)];
    cap_mask = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
    r_bpw    = 8'($urandom_range(0, 34));
    cap_mode = 7'($urandom);
    r_mode   = 32'($urandom_range(0, 31));
    if ($urandom_range(0, 7) == 0) r_mode[$urandom_range(5, 31)] = 1'b1;
    cap_freq = $urandom_range(0, 20);  r_freq = $urandom_range(0, 25);
    cap_wd = $urandom_range(0, 5);     r_wd = $urandom_range(0, 6);
    cap_su = $urandom_range(0, 5);     r_su = $urandom_range(0, 6);
    cap_ho = $urandom_range(0, 5);     r_ho = $urandom_range(0, 6);
    cap_in = $urandom_range(0, 5);     r_in = $urandom_range(0, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    set_clean();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid in reset", int'(valid), 0);
    chk("R11 launch in reset", int'(launch), 0);
    chk("R11 status in reset", int'(status), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R11 valid after reset", int'(valid), 0);
    chk("R11 status after reset", int'(status), 0);

    set_clean(); run("clean");
    chk("R2 clean expectation", exp_status(), 0);

    // R3 chip-select edge
    set_clean(); r_cs = 8'd3; run("R3 cs=count-1");
    set_clean(); r_cs = 8'd4; run("R3 cs=count");
    set_clean(); cap_cs = 8'd0; run("R3 count zero");

    // R4 word-length mask
    set_clean(); cap_mask = 32'h8000_0000; r_bpw = 8'd32; run("R4 bpw 32");
    set_clean(); cap_mask = 32'h8000_0000; r_bpw = 8'd33; run("R4 bpw 33");
    set_clean(); cap_mask = 32'h0000_0001; r_bpw = 8'd0;  run("R4 bpw 0");
    set_clean(); cap_mask = 32'h0000_0080; r_bpw = 8'd7;  run("R4 bpw unset");
    set_clean(); cap_mask = '0; r_bpw = 8'd200; run("R4 mask zero");

    // R5 lanes
    set_clean(); cap_tx = 3'b010; r_tx = 8'd4; run("R5 quad ok");
    set_clean(); cap_tx = 3'b011; r_tx = 8'd8; run("R5 octal denied");
    set_clean(); r_rx = 8'd0; run("R5 zero single");
    set_clean(); r_rx = 8'd3; run("R5 three");

    // R6 phase and polarity
    set_clean(); cap_mode[1:0] = 2'b11; run("R6 phase cap invalid");
    set_clean(); cap_mode[1:0] = 2'b01; r_mode[0] = 1'b1; run("R6 phase only0");
    set_clean(); cap_mode[3:2] = 2'b10; r_mode[1] = 1'b1; run("R6 pol only1 ok");
    set_clean(); cap_mode[3:2] = 2'b10; run("R6 pol only1 bad");

    // R7 feature bits and high mode bits
    set_clean(); cap_mode[5] = 1'b0; r_mode[3] = 1'b1; run("R7 lsb denied");
    set_clean(); r_mode = 32'h0000_001c; run("R7 all features");
    set_clean(); r_mode[5] = 1'b1; run("R7 bit5");

    // R8 frequency
    set_clean(); r_freq = 32'd100; run("R8 freq equal");
    set_clean(); r_freq = 32'd101; run("R8 freq over");
    set_clean(); cap_freq = '0; r_freq = 32'hffff_ffff; run("R8 unlimited");

    // R9 delays
    set_clean(); cap_ho = '0; r_ho = 32'd1; run("R9 hold unsupported");
    set_clean(); r_in = 32'd10; run("R9 inactive equal");
    set_clean(); r_su = 32'd11; run("R9 setup over");

    // R10 transfer failure, alone and with start
    set_clean();
    @(negedge clk) fail = 1'b1;
    @(negedge clk) fail = 1'b0;
    chk("R10 fail valid", int'(valid), 1);
    chk("R10 fail status", int'(status), 2);
    chk("R10 fail launch", int'(launch), 0);
    @(negedge clk) begin fail = 1'b1; start = 1'b1; end
    @(negedge clk) begin fail = 1'b0; start = 1'b0; end
    chk("R10 fail+start status", int'(status), 2);
    chk("R10 fail+start launch", int'(launch), 0);
    @(negedge clk);
    chk("R1 idle after fail", int'(valid), 0);

    for (int i = 0; i < 400; i++) begin
      randomize_fields();
      run("random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule